// File: doc/BRIEF.md
# UART Word-Level Loopback Unit

This block sits between the register front end of a serial port and its receive queue and implements the port's internal self-test path. A control word carries a loopback-enable bit and four software-driven modem outputs (DTR, RTS, Out1, Out2). While loopback is on, every control write cross-connects those outputs onto the four modem-status flags and rebuilds the modem-status interrupt bits from the result. Words written for transmission and break requests are placed straight into the receive queue, and anything arriving on the external receive input is thrown away.

While loopback is off, the modem-status flags track the external modem inputs, one cycle late. Transmit writes do not reach the receive queue. External receive characters are queued, zero-extended to the word width. All loopback handling acts on whole words, so serial bit timing and hardware flow control play no part. The receive queue is a small first-in first-out store that accepts up to two words per cycle: a transmit word and a break word can arrive together.

Top module: `uart_loopback_core`

## Requirements
- R1: A control write with loopback bit (ctrl_wdata[0]) set loads modem_flags from the written word on the next edge: DSR flag (bit 0) = DTR (ctrl bit 1), DCD flag (bit 1) = Out1 (ctrl bit 3), CTS flag (bit 2) = RTS (ctrl bit 2), RI flag (bit 3) = Out2 (ctrl bit 4).
- R2: The cross-mapping of R1 is applied even when the loopback bit is the only bit set in the written word, so all four flags become 0 whatever the external modem inputs are.
- R3: A control write with the loopback bit set replaces all four modem-status interrupt bits (ms_irq, same bit order as modem_flags) with the newly mapped flags, clearing any that map to 0; this takes priority over a clear mask given in the same cycle.
- R4: With loopback on, a transmit write pushes tx_data unchanged into the receive queue; rx_level rises by one on the next edge.
- R5: With loopback on, a line-control write that changes the break bit from 0 to 1 pushes a word with only bit 10 set; rewriting 1 while already 1 pushes nothing, and with loopback off a break pushes nothing.
- R6: With loopback on, external receive characters are discarded; with loopback off, each is queued as one word zero-extended from 8 bits.
- R7: With loopback off, modem_flags equal the external modem inputs of the previous cycle, and control writes change neither modem_flags nor ms_irq.
- R8: With loopback off, transmit writes are not placed in the receive queue.
- R9: The receive queue returns words in arrival order; a transmit word and a break word in the same cycle are stored transmit first; words beyond the capacity are dropped and rx_level never exceeds the depth.
- R10: Each bit set in ms_clr clears the matching ms_irq bit on the next edge, leaving the others unchanged.
- R11: Reset leaves loopback off, the break state 0, modem_flags and ms_irq 0, and the receive queue empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_wr | input | 1 | Control word write strobe |
| ctrl_wdata | input | 5 | Control word: [0] loopback, [1] DTR, [2] RTS, [3] Out1, [4] Out2 |
| ms_clr | input | 4 | Modem-status interrupt clear mask |
| lcr_wr | input | 1 | Line-control write strobe |
| lcr_brk | input | 1 | Break bit of the line-control write |
| tx_wr | input | 1 | Transmit word write strobe |
| tx_data | input | WORD_W | Transmit word |
| ext_rx_valid | input | 1 | External receive character valid |
| ext_rx_data | input | RXD_W | External receive character |
| ext_modem | input | 4 | External modem inputs: [0] DSR, [1] DCD, [2] CTS, [3] RI |
| rx_pop | input | 1 | Remove the head word of the receive queue |
| rx_valid | output | 1 | Receive queue not empty |
| rx_word | output | WORD_W | Head word of the receive queue |
| rx_level | output | $clog2(DEPTH)+1 | Words held in the receive queue |
| modem_flags | output | 4 | Modem-status flags: [0] DSR, [1] DCD, [2] CTS, [3] RI |
| ms_irq | output | 4 | Modem-status interrupt bits, same order as modem_flags |

## Verification
The bench builds the block with DEPTH = 4, WORD_W = 12 and RXD_W = 8, so a queue overflow and a full drain take only a handful of writes. At that size all 32 control words are swept, each against external modem inputs of all-zero and all-one, with the expected flags and interrupt bits computed from the cross-mapping in the bench. The 12-bit word keeps the break marker at bit 10 visible alongside full 8-bit characters.

// File: rtl/uart_lb_pkg.sv
package uart_lb_pkg;
  // control word bit positions
  localparam int CTRL_W  = 5;
  localparam int CB_LB   = 0;
  localparam int CB_DTR  = 1;
  localparam int CB_RTS  = 2;
  localparam int CB_OUT1 = 3;
  localparam int CB_OUT2 = 4;
  // modem status bit positions
  localparam int MS_W    = 4;
  localparam int MS_DSR  = 0;
  localparam int MS_DCD  = 1;
  localparam int MS_CTS  = 2;
  localparam int MS_RI   = 3;
  // break marker bit in a queued word
  localparam int BRK_POS = 10;

  typedef logic [CTRL_W-1:0] ctrl_t;
  typedef logic [MS_W-1:0]   modem_t;

  function automatic modem_t cross_map(input ctrl_t c);
    modem_t m;
    m         = '0;
    m[MS_DSR] = c[CB_DTR];
    m[MS_DCD] = c[CB_OUT1];
    m[MS_CTS] = c[CB_RTS];
    m[MS_RI]  = c[CB_OUT2];
    return m;
  endfunction
endpackage

// File: rtl/lb_modem_map.sv
module lb_modem_map
  import uart_lb_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   ctrl_wr,
  input  ctrl_t  ctrl_wdata,
  input  modem_t ms_clr,
  input  modem_t ext_modem,
  output logic   lb_on,
  output modem_t modem_flags,
  output modem_t ms_irq
);
  logic   lb_q, lb_n;
  modem_t flags_q, flags_n;
  modem_t irq_q, irq_n;
  logic   regen;

  always_comb begin
    lb_n    = lb_q;
    flags_n = flags_q;
    irq_n   = irq_q & ~ms_clr;
    regen   = ctrl_wr && ctrl_wdata[CB_LB];
    if (ctrl_wr) begin
      lb_n = ctrl_wdata[CB_LB];
    end
    if (regen) begin
      flags_n = cross_map(ctrl_wdata);
      irq_n   = cross_map(ctrl_wdata);
    end else if (!lb_n) begin
      flags_n = ext_modem;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lb_q    <= 1'b0;
      flags_q <= '0;
      irq_q   <= '0;
    end else begin
      lb_q    <= lb_n;
      flags_q <= flags_n;
      irq_q   <= irq_n;
    end
  end

  assign lb_on       = lb_q;
  assign modem_flags = flags_q;
  assign ms_irq      = irq_q;
endmodule

// File: rtl/lb_break_det.sv
module lb_break_det (
  input  logic clk,
  input  logic rst_n,
  input  logic lcr_wr,
  input  logic lcr_brk,
  input  logic lb_on,
  output logic brk_push
);
  logic brk_q, brk_n;

  always_comb begin
    brk_n = lcr_wr ? lcr_brk : brk_q;
  end

  assign brk_push = lcr_wr && lcr_brk && !brk_q && lb_on;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      brk_q <= 1'b0;
    end else begin
      brk_q <= brk_n;
    end
  end
endmodule

// File: rtl/lb_route.sv
module lb_route
  import uart_lb_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int RXD_W  = 8
) (
  input  logic              lb_on,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              brk_push,
  input  logic              ext_rx_valid,
  input  logic [RXD_W-1:0]  ext_rx_data,
  output logic [1:0]        push_n,
  output logic [WORD_W-1:0] word0,
  output logic [WORD_W-1:0] word1
);
  localparam logic [WORD_W-1:0] BRK_WORD = {{(WORD_W-1){1'b0}}, 1'b1} << BRK_POS;
  localparam logic [WORD_W-1:0] ZERO_W   = '0;

  logic [WORD_W-1:0] ext_word;
  assign ext_word = {{(WORD_W-RXD_W){1'b0}}, ext_rx_data};

  always_comb begin
    push_n = 2'd0;
    word0  = ZERO_W;
    word1  = ZERO_W;
    if (lb_on) begin
      if (tx_wr && brk_push) begin
        push_n = 2'd2;
        word0  = tx_data;
        word1  = BRK_WORD;
      end else if (tx_wr) begin
        push_n = 2'd1;
        word0  = tx_data;
      end else if (brk_push) begin
        push_n = 2'd1;
        word0  = BRK_WORD;
      end
    end else if (ext_rx_valid) begin
      push_n = 2'd1;
      word0  = ext_word;
    end
  end
endmodule

// File: rtl/lb_rxq.sv
module lb_rxq #(
  parameter int WORD_W = 12,
  parameter int DEPTH  = 16,
  localparam int PW    = $clog2(DEPTH),
  localparam int LVL_W = PW + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        push_n,
  input  logic [WORD_W-1:0] word0,
  input  logic [WORD_W-1:0] word1,
  input  logic              pop,
  output logic              valid,
  output logic [WORD_W-1:0] head,
  output logic [LVL_W-1:0]  level
);
  localparam logic [LVL_W-1:0] DEPTH_L = LVL_W'(DEPTH);
  localparam logic [PW-1:0]    ONE_P   = PW'(1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PW-1:0]     wp_q, wp_n, rp_q, rp_n;
  logic [LVL_W-1:0]  cnt_q, cnt_n;
  logic [LVL_W-1:0]  space, req, acc;
  logic              do_pop;
  logic              we0, we1;

  always_comb begin
    space  = DEPTH_L - cnt_q;
    req    = {{(LVL_W-2){1'b0}}, push_n};
    acc    = (req > space) ? space : req;
    do_pop = pop && (cnt_q != '0);
    we0    = acc != '0;
    we1    = acc > LVL_W'(1);
    wp_n   = wp_q + acc[PW-1:0];
    rp_n   = do_pop ? rp_q + ONE_P : rp_q;
    cnt_n  = cnt_q + acc - LVL_W'(do_pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      cnt_q <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (we0) begin
      mem[wp_q] <= word0;
    end
    if (we1) begin
      mem[wp_q + ONE_P] <= word1;
    end
  end

  assign valid = cnt_q != '0;
  assign head  = mem[rp_q];
  assign level = cnt_q;
endmodule

// File: rtl/uart_loopback_core.sv
module uart_loopback_core
  import uart_lb_pkg::*;
#(
  parameter int WORD_W = 12,
  parameter int RXD_W  = 8,
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_wr,
  input  logic [4:0]        ctrl_wdata,
  input  logic [3:0]        ms_clr,
  input  logic              lcr_wr,
  input  logic              lcr_brk,
  input  logic              tx_wr,
  input  logic [WORD_W-1:0] tx_data,
  input  logic              ext_rx_valid,
  input  logic [RXD_W-1:0]  ext_rx_data,
  input  logic [3:0]        ext_modem,
  input  logic              rx_pop,
  output logic              rx_valid,
  output logic [WORD_W-1:0] rx_word,
  output logic [LVL_W-1:0]  rx_level,
  output logic [3:0]        modem_flags,
  output logic [3:0]        ms_irq
);
  logic              lb_on;
  logic              brk_push;
  logic [1:0]        push_n;
  logic [WORD_W-1:0] word0, word1;

  lb_modem_map u_map (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctrl_wr    (ctrl_wr),
    .ctrl_wdata (ctrl_wdata),
    .ms_clr     (ms_clr),
    .ext_modem  (ext_modem),
    .lb_on      (lb_on),
    .modem_flags(modem_flags),
    .ms_irq     (ms_irq)
  );

  lb_break_det u_brk (
    .clk     (clk),
    .rst_n   (rst_n),
    .lcr_wr  (lcr_wr),
    .lcr_brk (lcr_brk),
    .lb_on   (lb_on),
    .brk_push(brk_push)
  );

  lb_route #(.WORD_W(WORD_W), .RXD_W(RXD_W)) u_route (
    .lb_on       (lb_on),
    .tx_wr       (tx_wr),
    .tx_data     (tx_data),
    .brk_push    (brk_push),
    .ext_rx_valid(ext_rx_valid),
    .ext_rx_data (ext_rx_data),
    .push_n      (push_n),
    .word0       (word0),
    .word1       (word1)
  );

  lb_rxq #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_rxq (
    .clk   (clk),
    .rst_n (rst_n),
    .push_n(push_n),
    .word0 (word0),
    .word1 (word1),
    .pop   (rx_pop),
    .valid (rx_valid),
    .head  (rx_word),
    .level (rx_level)
  );
endmodule

// File: rtl/uart_loopback_chk.sv
module uart_loopback_chk
  import uart_lb_pkg::*;
#(
  parameter int DEPTH  = 16,
  localparam int LVL_W = $clog2(DEPTH) + 1
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_wr,
  input logic [4:0]       ctrl_wdata,
  input logic [3:0]       ext_modem,
  input logic [3:0]       modem_flags,
  input logic [3:0]       ms_irq,
  input logic             lb_on,
  input logic             tx_wr,
  input logic             lcr_wr,
  input logic             ext_rx_valid,
  input logic             rx_pop,
  input logic [LVL_W-1:0] rx_level
);
  p_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[CB_LB]) |=> modem_flags == cross_map($past(ctrl_wdata)));

  p_irq_regen_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr && ctrl_wdata[CB_LB]) |=> ms_irq == modem_flags);

  p_follow_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_wr ? !ctrl_wdata[CB_LB] : !lb_on) |=> modem_flags == $past(ext_modem));

  p_tx_push_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_on && tx_wr && !lcr_wr && !rx_pop && (rx_level < LVL_W'(DEPTH)))
      |=> rx_level == $past(rx_level) + LVL_W'(1));

  p_no_ext_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (lb_on && ext_rx_valid && !tx_wr && !lcr_wr && !rx_pop) |=> $stable(rx_level));

  p_no_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!lb_on && !ext_rx_valid && !rx_pop) |=> $stable(rx_level));

  p_level_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_level <= LVL_W'(DEPTH));
endmodule

bind uart_loopback_core uart_loopback_chk #(.DEPTH(DEPTH)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ctrl_wr     (ctrl_wr),
  .ctrl_wdata  (ctrl_wdata),
  .ext_modem   (ext_modem),
  .modem_flags (modem_flags),
  .ms_irq      (ms_irq),
  .lb_on       (lb_on),
  .tx_wr       (tx_wr),
  .lcr_wr      (lcr_wr),
  .ext_rx_valid(ext_rx_valid),
  .rx_pop      (rx_pop),
  .rx_level    (rx_level)
);

// File: tb/test_uart_loopback_core.sv
module test_uart_loopback_core;
  localparam int WORD_W = 12;
  localparam int RXD_W  = 8;
  localparam int DEPTH  = 4;
  localparam int LVL_W  = $clog2(DEPTH) + 1;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              ctrl_wr;
  logic [4:0]        ctrl_wdata;
  logic [3:0]        ms_clr;
  logic              lcr_wr, lcr_brk;
  logic              tx_wr;
  logic [WORD_W-1:0] tx_data;
  logic              ext_rx_valid;
  logic [RXD_W-1:0]  ext_rx_data;
  logic [3:0]        ext_modem;
  logic              rx_pop;
  logic              rx_valid;
  logic [WORD_W-1:0] rx_word;
  logic [LVL_W-1:0]  rx_level;
  logic [3:0]        modem_flags, ms_irq;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  always #4 clk = ~clk;

  uart_loopback_core #(.WORD_W(WORD_W), .RXD_W(RXD_W), .DEPTH(DEPTH)) i_uart_loopback_core (
    .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .ms_clr(ms_clr),
    .lcr_wr(lcr_wr), .lcr_brk(lcr_brk), .tx_wr(tx_wr), .tx_data(tx_data),
    .ext_rx_valid(ext_rx_valid), .ext_rx_data(ext_rx_data), .ext_modem(ext_modem),
    .rx_pop(rx_pop), .rx_valid(rx_valid), .rx_word(rx_word), .rx_level(rx_level),
    .modem_flags(modem_flags), .ms_irq(ms_irq)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 50000) begin
      checks = checks + 1;
      errors = errors + 1;
      $display("FAIL watchdog: got %0d cycles expected completion", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] xmap(input logic [4:0] c);
    return {c[4], c[2], c[3], c[1]};
  endfunction

  task automatic idle_inputs();
    ctrl_wr = 0; ctrl_wdata = '0; ms_clr = '0; lcr_wr = 0; lcr_brk = 0;
    tx_wr = 0; tx_data = '0; ext_rx_valid = 0; ext_rx_data = '0; rx_pop = 0;
  endtask

  // one-cycle stimulus, returns at the following negedge
  task automatic ctrl_write(input logic [4:0] v, input logic [3:0] clr);
    @(negedge clk); ctrl_wr = 1; ctrl_wdata = v; ms_clr = clr;
    @(negedge clk); ctrl_wr = 0; ms_clr = '0;
  endtask

  task automatic irq_clear(input logic [3:0] clr);
    @(negedge clk); ms_clr = clr;
    @(negedge clk); ms_clr = '0;
  endtask

  task automatic push(input logic tx, input logic [WORD_W-1:0] td, input logic lw,
                      input logic lb, input logic ev, input logic [RXD_W-1:0] ed);
    @(negedge clk);
    tx_wr = tx; tx_data = td; lcr_wr = lw; lcr_brk = lb; ext_rx_valid = ev; ext_rx_data = ed;
    @(negedge clk);
    tx_wr = 0; lcr_wr = 0; ext_rx_valid = 0;
  endtask

  task automatic pop_check(input string req, input logic [WORD_W-1:0] exp);
    @(negedge clk);
    chk(req, {31'd0, rx_valid}, 32'd1);
    chk(req, {20'd0, rx_word}, {20'd0, exp});
    rx_pop = 1;
    @(negedge clk);
    rx_pop = 0;
  endtask

  logic [3:0] irq_m;
  logic [3:0] exp_f;

  initial begin
    idle_inputs();
    rst_n = 0;
    ext_modem = 4'b1010;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 flags", {28'd0, modem_flags}, 32'd0);
    chk("R11 irq", {28'd0, ms_irq}, 32'd0);
    chk("R11 level", {29'd0, rx_level}, 32'd0);
    chk("R11 valid", {31'd0, rx_valid}, 32'd0);
    rst_n = 1;
    @(negedge clk);
    chk("R7 follow ext", {28'd0, modem_flags}, 32'hA);
    ext_modem = 4'b0101;
    @(negedge clk);
    chk("R7 follow ext change", {28'd0, modem_flags}, 32'h5);
    ctrl_write(5'b11110, 4'h0);
    chk("R7 ctrl write no effect flags", {28'd0, modem_flags}, 32'h5);
    chk("R7 ctrl write no effect irq", {28'd0, ms_irq}, 32'h0);

    // exhaustive control sweep: R1, R2, R3, R7
    irq_m = 4'h0;
    for (int v = 0; v < 32; v++) begin
      for (int k = 0; k < 2; k++) begin
        ext_modem = (k == 0) ? 4'h0 : 4'hF;
        ctrl_write(v[4:0], 4'h0);
        if (v[0]) begin
          exp_f = xmap(v[4:0]);
          irq_m = xmap(v[4:0]);
        end else begin
          exp_f = ext_modem;
        end
        if (v == 1) begin
          chk("R2 only loopback bit", {28'd0, modem_flags}, 32'd0);
        end else if (v[0]) begin
          chk("R1 cross map", {28'd0, modem_flags}, {28'd0, exp_f});
        end else begin
          chk("R7 loopback off flags", {28'd0, modem_flags}, {28'd0, exp_f});
        end
        chk(v[0] ? "R3 irq regen" : "R7 irq untouched", {28'd0, ms_irq}, {28'd0, irq_m});
      end
    end

    // R10 clear mask, R3 priority over same-cycle clear
    ctrl_write(5'b11111, 4'h0);
    chk("R3 all set", {28'd0, ms_irq}, 32'hF);
    irq_clear(4'b0101);
    chk("R10 clear mask", {28'd0, ms_irq}, 32'hA);
    ctrl_write(5'b00011, 4'hF);
    chk("R3 regen beats clear", {28'd0, ms_irq}, 32'h1);
    chk("R3 regen flags", {28'd0, modem_flags}, 32'h1);

    // loopback on: R4, R6, R9
    push(1, 12'h0A5, 0, 0, 0, 8'h00);
    chk("R4 tx pushed", {29'd0, rx_level}, 32'd1);
    push(1, 12'h3C1, 0, 0, 0, 8'h00);
    chk("R4 tx pushed 2", {29'd0, rx_level}, 32'd2);
    pop_check("R9 order first", 12'h0A5);
    pop_check("R9 order second", 12'h3C1);
    push(0, 12'h000, 0, 0, 1, 8'h77);
    chk("R6 ext dropped in loopback", {29'd0, rx_level}, 32'd0);

    // R5 break handling
    push(0, 12'h000, 1, 1, 0, 8'h00);
    chk("R5 break pushed", {29'd0, rx_level}, 32'd1);
    pop_check("R5 break word", 12'h400);
    push(0, 12'h000, 1, 1, 0, 8'h00);
    chk("R5 break held no push", {29'd0, rx_level}, 32'd0);
    push(0, 12'h000, 1, 0, 0, 8'h00);
    chk("R5 break release no push", {29'd0, rx_level}, 32'd0);
    push(1, 12'h012, 1, 1, 0, 8'h00);
    chk("R9 dual push level", {29'd0, rx_level}, 32'd2);
    pop_check("R9 tx before break", 12'h012);
    pop_check("R9 break after tx", 12'h400);
    push(0, 12'h000, 1, 0, 0, 8'h00);

    // R9 overflow
    for (int i = 1; i <= 5; i++) begin
      push(1, 12'h100 + 12'(i), 0, 0, 0, 8'h00);
    end
    chk("R9 level capped", {29'd0, rx_level}, DEPTH);
    for (int i = 1; i <= 4; i++) begin
      pop_check("R9 drain order", 12'h100 + 12'(i));
    end
    chk("R9 empty after drain", {31'd0, rx_valid}, 32'd0);

    // loopback off: R8, R5, R6
    ctrl_write(5'b00000, 4'h0);
    push(1, 12'h0FF, 0, 0, 0, 8'h00);
    chk("R8 tx not looped", {29'd0, rx_level}, 32'd0);
    push(0, 12'h000, 1, 1, 0, 8'h00);
    chk("R5 break off no push", {29'd0, rx_level}, 32'd0);
    push(0, 12'h000, 1, 0, 0, 8'h00);
    push(0, 12'h000, 0, 0, 1, 8'h5A);
    chk("R6 ext queued", {29'd0, rx_level}, 32'd1);
    pop_check("R6 ext zero extended", 12'h05A);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule